// File: doc/BRIEF.md
# Loadable Prime-Radix Digit Counter

This block keeps a running count as a vector of digits in a prime radix (2, 3, 5, 7, 11, 13 or 17, chosen at elaboration) instead of as a binary word. Software or a controller first writes a start value that is already expressed in that radix. From then on the block adds one to the count on every cycle in which the increment enable is high. Each digit wraps from the radix minus one to zero and carries into the next higher digit. The whole digit vector is presented on every cycle, so that digit-sum logic further down the pipeline can read it without any conversion.

Several instances, one for each radix, can be started together on equivalent start values and enabled by one common signal. They then step in lockstep, and every instance represents the same integer in its own radix. By default the digit count is the smallest number of digits that holds any 72-bit value: 72 for radix 2, 46 for 3, 32 for 5, 26 for 7, 21 for 11, 20 for 13 and 18 for 17.

The carry is resolved from registered per-digit "at maximum" flags, which are grouped into segments. This keeps the path from register to register short enough for a clock of about 100 MHz, even with many digits.

Top module: `radix_digit_counter`

## Requirements
- R1: While rst_n is low, and after its release until the first load or increment, count_o is all zeros and wrap_o and load_err_o are 0.
- R2: Digit i (i = 0 is the least significant) occupies count_o[i*DW +: DW], where DW = ceil(log2(RADIX)) (1 for radix 2). The value held is the sum of digit_i * RADIX^i, and load_digits_i uses the same layout.
- R3: When load_i is high at a clock edge, count_o after that edge equals load_digits_i, with illegal digits replaced by zero. The load takes priority over inc_en_i, and no wrap is reported in that cycle.
- R4: When inc_en_i is high and load_i is low at an edge, the value after the edge is the previous value plus one, modulo RADIX^NUM_DIGITS, with carries crossing digits and segments.
- R5: When both inc_en_i and load_i are low at an edge, count_o, wrap_o = 0 and load_err_o are unchanged.
- R6: A loaded digit whose value is RADIX or higher is stored as 0. load_err_o goes to 1 after that load and stays at 1 until the next load, which sets it again only if that load also contains an illegal digit.
- R7: An increment from the all-maximum value (every digit RADIX-1) gives all zeros, and wrap_o is 1 for exactly the one cycle that follows that edge.
- R8: Every digit of count_o is always below RADIX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load the start digits this cycle |
| load_digits_i | input | NUM_DIGITS*DW | Start value as packed radix digits |
| inc_en_i | input | 1 | Add one this cycle when not loading |
| count_o | output | NUM_DIGITS*DW | Current count as packed radix digits |
| wrap_o | output | 1 | One-cycle pulse after the count rolls over to zero |
| load_err_o | output | 1 | The last load contained a digit of RADIX or above |

## Verification
Every result is registered once, so count_o, wrap_o and load_err_o reflect the inputs that were present at the previous rising edge. There is no further latency. The bench changes its inputs on the falling edge and samples a quarter period after the rising edge that follows. Every comparison therefore falls one edge after its stimulus. A small configuration (radix 3, four digits, two-digit segments) is swept over all 81 values, both for loading and for a single increment from every start value. A continuous run goes through the wrap, and a gated run checks that the count holds while the enable is low.

// File: rtl/radix_ctr_pkg.sv
// radix_ctr_pkg: elaboration-time helpers shared by the radix counter.
// Assumes radix values of 2 or more; widths are computed, not tabulated.
package radix_ctr_pkg;

    // Bits needed to store one digit of the given radix.
    function automatic int digit_width(input int radix);
        int w;
        w = 1;
        while ((1 << w) < radix) w++;
        return w;
    endfunction

    // Smallest digit count whose range covers every value of nbits bits.
    function automatic int digits_for_bits(input int radix, input int nbits);
        logic [95:0] v;
        int n;
        v = (96'd1 << nbits) - 96'd1;
        n = 0;
        while (v != 96'd0) begin
            v = v / 96'(radix);
            n++;
        end
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/radix_digit_cell.sv
// radix_digit_cell: one stored digit of the counter.
// Holds a digit below RADIX, loads it (with illegal values forced to 0),
// or steps it with a carry input. Also registers a flag telling whether
// the stored digit is at RADIX-1, so the carry logic reads only flops.
module radix_digit_cell #(
    parameter int RADIX = 3,
    parameter int DW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic          carry_i,
    output logic [DW-1:0] digit_o,
    output logic          at_max_o,
    output logic          bad_o
);
    localparam logic [DW:0]   RADIX_EXT = (DW+1)'(RADIX);
    localparam logic [DW-1:0] TOP_DIGIT = DW'(RADIX - 1);

    logic [DW-1:0] digit_q;
    logic [DW-1:0] digit_d;
    logic          at_max_q;

    // Flag a start digit that does not belong to this radix.
    always_comb bad_o = ({1'b0, load_val_i} >= RADIX_EXT);

    // Select the next digit: load, step with wrap, or hold.
    always_comb begin
        if (load_i)
            digit_d = bad_o ? '0 : load_val_i;
        else if (carry_i)
            digit_d = (digit_q == TOP_DIGIT) ? '0 : digit_q + DW'(1);
        else
            digit_d = digit_q;
    end

    // Store the digit and its at-maximum flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q  <= '0;
            at_max_q <= 1'b0;
        end else begin
            digit_q  <= digit_d;
            at_max_q <= (digit_d == TOP_DIGIT);
        end
    end

    assign digit_o  = digit_q;
    assign at_max_o = at_max_q;
endmodule

// File: rtl/radix_digit_segment.sv
// radix_digit_segment: a group of CNT digit cells with a local carry chain.
// The carry into the group comes from the top level. The group reports
// whether all its digits sit at RADIX-1, which allows the carry between
// groups to skip the group. Assumes CNT of 1 or more.
module radix_digit_segment #(
    parameter int RADIX = 3,
    parameter int DW    = 2,
    parameter int CNT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CNT*DW-1:0] load_digits_i,
    input  logic              carry_i,
    output logic [CNT*DW-1:0] digits_o,
    output logic              all_max_o,
    output logic              any_bad_o
);
    logic [CNT-1:0] at_max;
    logic [CNT-1:0] bad;
    logic [CNT:0]   carry;

    // Ripple the carry through registered at-maximum flags only.
    always_comb begin
        carry[0] = carry_i;
        for (int k = 0; k < CNT; k++)
            carry[k+1] = carry[k] & at_max[k];
    end

    genvar k;
    generate
        for (k = 0; k < CNT; k++) begin : g_cell
            radix_digit_cell #(.RADIX(RADIX), .DW(DW)) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_i     (load_i),
                .load_val_i (load_digits_i[k*DW +: DW]),
                .carry_i    (carry[k]),
                .digit_o    (digits_o[k*DW +: DW]),
                .at_max_o   (at_max[k]),
                .bad_o      (bad[k])
            );
        end
    endgenerate

    // Summarise the group for the carry between groups and for the error flag.
    always_comb begin
        all_max_o = &at_max;
        any_bad_o = |bad;
    end
endmodule

// File: rtl/radix_digit_counter.sv
// radix_digit_counter: loadable up-counter held as base-RADIX digits.
// The digits are split into segments of SEG_DIGITS. The carry into a
// segment is the enable ANDed with the registered all-maximum flags of the
// lower segments, so no digit adder lies on the carry path. The default
// digit count covers every 72-bit value. RADIX is expected to be a prime
// from 2 to 17, but any value of 2 or more works.
module radix_digit_counter
    import radix_ctr_pkg::*;
#(
    parameter int  RADIX      = 3,
    parameter int  NUM_DIGITS = digits_for_bits(RADIX, 72),
    parameter int  SEG_DIGITS = 8,
    localparam int DW         = digit_width(RADIX),
    localparam int VW         = NUM_DIGITS * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [VW-1:0] load_digits_i,
    input  logic          inc_en_i,
    output logic [VW-1:0] count_o,
    output logic          wrap_o,
    output logic          load_err_o
);
    localparam int NSEG = (NUM_DIGITS + SEG_DIGITS - 1) / SEG_DIGITS;

    logic [NSEG-1:0] seg_carry;
    logic [NSEG-1:0] seg_all_max;
    logic [NSEG-1:0] seg_bad;
    logic            roll_over;
    logic            wrap_q;
    logic            err_q;

    // Carry between segments: the enable passes only the groups below that are at maximum.
    always_comb begin
        logic run;
        run = inc_en_i & ~load_i;
        for (int g = 0; g < NSEG; g++) begin
            seg_carry[g] = run;
            run          = run & seg_all_max[g];
        end
        roll_over = run;
    end

    genvar g;
    generate
        for (g = 0; g < NSEG; g++) begin : g_seg
            localparam int LO  = g * SEG_DIGITS;
            localparam int CNT = ((NUM_DIGITS - LO) < SEG_DIGITS) ?
                                 (NUM_DIGITS - LO) : SEG_DIGITS;
            radix_digit_segment #(.RADIX(RADIX), .DW(DW), .CNT(CNT)) u_seg (
                .clk           (clk),
                .rst_n         (rst_n),
                .load_i        (load_i),
                .load_digits_i (load_digits_i[LO*DW +: CNT*DW]),
                .carry_i       (seg_carry[g]),
                .digits_o      (count_o[LO*DW +: CNT*DW]),
                .all_max_o     (seg_all_max[g]),
                .any_bad_o     (seg_bad[g])
            );
        end
    endgenerate

    // Register the wrap pulse and the sticky load-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            wrap_q <= roll_over;
            if (load_i)
                err_q <= |seg_bad;
        end
    end

    assign wrap_o     = wrap_q;
    assign load_err_o = err_q;
endmodule

// File: rtl/radix_digit_counter_chk.sv
// radix_digit_counter_chk: port-level properties of radix_digit_counter,
// attached to every instance by the bind below.
module radix_digit_counter_chk #(
    parameter int RADIX      = 3,
    parameter int NUM_DIGITS = 4,
    parameter int DW         = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_i,
    input logic [NUM_DIGITS*DW-1:0] load_digits_i,
    input logic                     inc_en_i,
    input logic [NUM_DIGITS*DW-1:0] count_o,
    input logic                     wrap_o,
    input logic                     load_err_o
);
    logic any_bad_in;
    logic past_valid;

    // Recompute from the input port whether a start digit is illegal.
    always_comb begin
        any_bad_in = 1'b0;
        for (int i = 0; i < NUM_DIGITS; i++)
            if (int'(load_digits_i[i*DW +: DW]) >= RADIX) any_bad_in = 1'b1;
    end

    // Mark the cycles after the first edge that follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // R1: the state is cleared by reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !wrap_o && !load_err_o));

    // R3: a load of legal digits shows up unchanged.
    a_r3_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !any_bad_in) |=> (count_o == $past(load_digits_i) && !wrap_o));

    // R5: no load and no enable hold everything.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !load_i && !inc_en_i) |=>
            ($stable(count_o) && !wrap_o && $stable(load_err_o)));

    // R6: the error flag follows the legality of the last load.
    a_r6_err_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (load_err_o == $past(any_bad_in)));

    // R4: an increment always changes the count.
    a_r4_inc_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && inc_en_i && !load_i) |=> !$stable(count_o));

    // R7: a wrap leaves all zeros and lasts one cycle.
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (count_o == '0));
    a_r7_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

    // R8: every digit stays below the radix.
    genvar d;
    generate
        for (d = 0; d < NUM_DIGITS; d++) begin : g_dig
            a_r8_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
                int'(count_o[d*DW +: DW]) < RADIX);
        end
    endgenerate
endmodule

bind radix_digit_counter radix_digit_counter_chk #(
    .RADIX(RADIX), .NUM_DIGITS(NUM_DIGITS), .DW(DW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_i),
    .load_digits_i (load_digits_i),
    .inc_en_i      (inc_en_i),
    .count_o       (count_o),
    .wrap_o        (wrap_o),
    .load_err_o    (load_err_o)
);

// File: tb/sim_radix_digit_counter.sv
// sim_radix_digit_counter: exhaustive bench on radix 3, four digits,
// two-digit segments (81 states, carry crossing a segment boundary).
module sim_radix_digit_counter;
    localparam int CLK_PERIOD = 10;
    localparam int R   = 3;
    localparam int ND  = 4;
    localparam int DWB = 2;
    localparam int MOD = 81;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_i = 1'b0;
    logic [ND*DWB-1:0] load_digits_i = '0;
    logic            inc_en_i = 1'b0;
    logic [ND*DWB-1:0] count_o;
    logic            wrap_o;
    logic            load_err_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix_digit_counter #(.RADIX(R), .NUM_DIGITS(ND), .SEG_DIGITS(2)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load_i),
        .load_digits_i (load_digits_i),
        .inc_en_i      (inc_en_i),
        .count_o       (count_o),
        .wrap_o        (wrap_o),
        .load_err_o    (load_err_o)
    );

    // R2 layout: digit i at bits [2i+1:2i], value = sum d_i * 3^i.
    function automatic logic [7:0] enc(input int v);
        logic [7:0] r;
        int x;
        x = v;
        for (int i = 0; i < ND; i++) begin
            r[i*DWB +: DWB] = 2'(x % R);
            x = x / R;
        end
        return r;
    endfunction

    function automatic int dec(input logic [7:0] d);
        int v;
        int p;
        v = 0;
        p = 1;
        for (int i = 0; i < ND; i++) begin
            v = v + int'(d[i*DWB +: DWB]) * p;
            p = p * R;
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive on the falling edge, then sample a quarter period after the rising edge.
    task automatic tick(input logic ld, input logic [7:0] val, input logic inc);
        @(negedge clk);
        load_i        = ld;
        load_digits_i = val;
        inc_en_i      = inc;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic expect_state(input string req, input int v, input bit w, input bit e);
        check(count_o == enc(v), req, dec(count_o), v);
        check(wrap_o == w, {req, " wrap"}, int'(wrap_o), int'(w));
        check(load_err_o == e, {req, " err"}, int'(load_err_o), int'(e));
    endtask

    initial begin
        logic [7:0] raw;
        // R1: reset state, during and after reset.
        tick(1'b0, 8'h00, 1'b0);
        tick(1'b0, 8'h00, 1'b0);
        expect_state("R1 in reset", 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick(1'b0, 8'h00, 1'b0);
        expect_state("R1 after reset", 0, 1'b0, 1'b0);

        // R2/R3/R4/R7: load every value, then a single increment from it.
        for (int v = 0; v < MOD; v++) begin
            tick(1'b1, enc(v), 1'b0);
            expect_state("R3 load", v, 1'b0, 1'b0);
            tick(1'b0, 8'h00, 1'b1);
            expect_state("R4 step", (v + 1) % MOD, (v == MOD - 1), 1'b0);
        end

        // R4/R7: continuous run through the wrap.
        tick(1'b1, enc(0), 1'b0);
        for (int k = 1; k <= MOD + 3; k++) begin
            tick(1'b0, 8'h00, 1'b1);
            expect_state("R7 run", k % MOD, (k == MOD), 1'b0);
        end

        // R5: an enable that is high on alternate cycles; the count holds on the others.
        tick(1'b1, enc(70), 1'b0);
        for (int k = 0; k < 24; k++) begin
            tick(1'b0, 8'h00, 1'(k % 2));
            expect_state("R5 gated", (70 + (k + 1) / 2) % MOD,
                         ((k % 2) == 1) && (((70 + (k + 1) / 2) % MOD) == 0), 1'b0);
        end

        // R3: a load with the enable high wins, even at the all-maximum value.
        tick(1'b1, enc(80), 1'b0);
        tick(1'b1, enc(80), 1'b1);
        expect_state("R3 priority", 80, 1'b0, 1'b0);
        tick(1'b1, enc(5), 1'b1);
        expect_state("R3 priority", 5, 1'b0, 1'b0);

        // R6/R8: illegal digit (3) in each position becomes 0; the flag holds until the next load.
        for (int p = 0; p < ND; p++) begin
            raw = enc(40);
            raw[p*DWB +: DWB] = 2'd3;
            tick(1'b1, raw, 1'b0);
            raw[p*DWB +: DWB] = 2'd0;
            expect_state("R6 illegal", dec(raw), 1'b0, 1'b1);
            tick(1'b0, 8'h00, 1'b1);
            expect_state("R6 sticky", (dec(raw) + 1) % MOD, 1'b0, 1'b1);
            tick(1'b0, 8'h00, 1'b0);
            expect_state("R6 hold", (dec(raw) + 1) % MOD, 1'b0, 1'b1);
            tick(1'b1, enc(p), 1'b0);
            expect_state("R6 cleared", p, 1'b0, 1'b0);
        end
        tick(1'b1, 8'hFF, 1'b0);
        expect_state("R6 all illegal", 0, 1'b0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule